// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block runs the multi-cycle stack traffic around a CPU's control transfers. From idle it can take a non-maskable interrupt, a maskable interrupt request, or a start command that asks for a software break, a reset entry, a subroutine call, a subroutine return or a return from interrupt. For each sequence it drives byte-wide writes or reads on a memory port. The stack lives in a fixed page, addressed as `{STACK_PAGE, SP}`. Interrupt-style entries then fetch the new program counter from a fixed vector.

The core supplies PC, SP and status on its inputs at the cycle a sequence is accepted. The sequencer returns the new PC, SP and status on registered outputs, which stay valid from the `done_o` pulse until the next sequence completes. `kind_o` reports which sequence was accepted. The memory port reads combinationally: `mem_rdata_i` must reflect `mem_addr_o` within the same cycle.

Top module: `isr_stack_seq`

## Requirements
- R1: While `rst_ni` is low, `sp_o` = 0xFD, `status_o` = 0x34, `pc_o` = 0, and `busy_o`, `done_o` and `mem_we_o` are all 0.
- R2: An NMI, IRQ or break entry with stack pointer S and program counter P writes P[15:8] at `{page,S}`, then P[7:0] at `{page,S-1}`, then the status byte at `{page,S-2}`. It returns `sp_o` = S-3 and `pc_o` = {byte at V+1, byte at V}, where V is 0xFFFA for NMI, 0xFFFC for reset, and 0xFFFE for both IRQ and break.
- R3: Break, IRQ, NMI and reset entries take 7 cycles from the accepting clock edge to the cycle in which `done_o` is high. Call and return take 3 cycles and return-from-interrupt takes 4. `busy_o` is high for every cycle in between. `done_o` is a one-cycle pulse and is never high together with `busy_o`.
- R4: Status bit 2 (interrupt disable) is set in `status_o` after every interrupt-style entry and is not set in the pushed byte. For a break, status bit 4 is set both in the pushed byte and in `status_o`.
- R5: NMI is edge-triggered. A rising edge of `nmi_i` latches a request that is taken at the first idle cycle, even while the block is busy with another sequence. When an NMI and an IRQ are both pending, the NMI wins. A held-high `nmi_i` starts only one entry.
- R6: An IRQ (`irq_i` high) is taken only while `status_i` bit 2 is clear. While that bit is set, `irq_i` starts nothing and writes nothing.
- R7: A call (`cmd_i` = 0) writes (P-1)[15:8] at `{page,S}` and (P-1)[7:0] at `{page,S-1}`. It returns `sp_o` = S-2 and `pc_o` = `tgt_i`.
- R8: A return (`cmd_i` = 1) reads the low byte at `{page,S+1}` and the high byte at `{page,S+2}`. It returns `pc_o` = {high, low} + 1 and `sp_o` = S+2.
- R9: A return from interrupt (`cmd_i` = 2) reads the status from `{page,S+1}`, the PC low byte from `{page,S+2}` and the PC high byte from `{page,S+3}`. It returns these values unchanged, with `sp_o` = S+3.
- R10: A reset entry (`cmd_i` = 4) performs no memory write. It returns `sp_o` = S-3, takes `pc_o` from the reset vector, and returns `status_o` with bit 2 set. Break is `cmd_i` = 3. `cmd_i` values 5 to 7 are ignored.
- R11: The stack pointer wraps modulo 256, so every stack access stays inside the stack page.
- R12: Every write targets the stack page. A write and a read never occur in the same cycle. Bus activity only happens while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable interrupt line, rising-edge sensitive |
| irq_i | input | 1 | Maskable interrupt request, level |
| start_i | input | 1 | Start a commanded sequence (taken only when idle and no interrupt wins) |
| cmd_i | input | 3 | 0 call, 1 return, 2 return-from-interrupt, 3 break, 4 reset |
| pc_i | input | 16 | Current program counter (return address for a call) |
| sp_i | input | 8 | Current stack pointer |
| status_i | input | 8 | Current status byte |
| tgt_i | input | 16 | Call target |
| mem_rdata_i | input | 8 | Read data for mem_addr_o, same cycle |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_wdata_o | output | 8 | Write data |
| pc_o | output | 16 | Resulting program counter |
| sp_o | output | 8 | Resulting stack pointer |
| status_o | output | 8 | Resulting status byte |
| kind_o | output | 3 | Accepted sequence: 0..4 as cmd_i, 5 NMI, 6 IRQ, 7 none yet |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 8-bit data, stack page 0x01 and vectors at the top of the 16-bit space. With an 8-bit stack pointer, every start value from 0x00 to 0xFF can be swept through break, return-from-interrupt, call and return, and each result is compared with arithmetic in the bench. That sweep reaches the wrap of pushes below 0x00 and of pops above 0xFF. The fixed 64 KiB vector space is modelled as a computed byte pattern, so the order in which the low and high vector bytes are read shows up directly in `pc_o`.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic [2:0] {
    K_CALL = 3'd0, K_RET = 3'd1, K_RETI = 3'd2, K_BRK = 3'd3,
    K_RST  = 3'd4, K_NMI = 3'd5, K_IRQ  = 3'd6, K_NONE = 3'd7
  } kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PAD, S_PUSH_H, S_PUSH_L, S_PUSH_P,
    S_VEC_L, S_VEC_H, S_POP_P, S_POP_L, S_POP_H
  } state_e;

  localparam int unsigned FLAG_I = 2;
  localparam int unsigned FLAG_B = 4;
endpackage

// File: rtl/isr_nmi_edge.sv
module isr_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clear_i,
  output logic req_o
);
  logic nmi_q, pend_q, rise;

  assign rise  = nmi_i & ~nmi_q;
  assign req_o = pend_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= req_o & ~clear_i;
    end
  end
endmodule

// File: rtl/isr_arbiter.sv
module isr_arbiter
  import isr_pkg::*;
(
  input  logic       idle_i,
  input  logic       nmi_req_i,
  input  logic       irq_i,
  input  logic       i_flag_i,
  input  logic       start_i,
  input  logic [2:0] cmd_i,
  output logic       go_o,
  output logic       take_nmi_o,
  output kind_e      kind_o
);
  always_comb begin
    go_o       = 1'b0;
    take_nmi_o = 1'b0;
    kind_o     = K_NONE;
    if (idle_i) begin
      if (nmi_req_i) begin
        go_o       = 1'b1;
        take_nmi_o = 1'b1;
        kind_o     = K_NMI;
      end else if (irq_i && !i_flag_i) begin
        go_o   = 1'b1;
        kind_o = K_IRQ;
      end else if (start_i && cmd_i <= 3'd4) begin
        go_o   = 1'b1;
        kind_o = kind_e'(cmd_i);
      end
    end
  end
endmodule

// File: rtl/isr_stack_seq.sv
module isr_stack_seq
  import isr_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0] NMI_VEC = 16'hFFFA,
  parameter logic [2*DATA_W-1:0] RST_VEC = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] IRQ_VEC = 16'hFFFE,
  parameter logic [DATA_W-1:0] INIT_SP  = 8'hFD,
  parameter logic [DATA_W-1:0] INIT_ST  = 8'h34
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  nmi_i,
  input  logic                  irq_i,
  input  logic                  start_i,
  input  logic [2:0]            cmd_i,
  input  logic [2*DATA_W-1:0]   pc_i,
  input  logic [DATA_W-1:0]     sp_i,
  input  logic [DATA_W-1:0]     status_i,
  input  logic [2*DATA_W-1:0]   tgt_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic [2*DATA_W-1:0]   mem_addr_o,
  output logic                  mem_we_o,
  output logic                  mem_re_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic [2*DATA_W-1:0]   pc_o,
  output logic [DATA_W-1:0]     sp_o,
  output logic [DATA_W-1:0]     status_o,
  output logic [2:0]            kind_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int unsigned ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ONE_D  = DATA_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);
  localparam logic [DATA_W-1:0] I_MASK = DATA_W'(1) << FLAG_I;
  localparam logic [DATA_W-1:0] B_MASK = DATA_W'(1) << FLAG_B;

  state_e              state_q;
  kind_e               kind_q, kind_a;
  logic                go, take_nmi, nmi_req;
  logic [DATA_W-1:0]   sp_q, st_q, sp_inc, sp_dec;
  logic [ADDR_W-1:0]   val_q, tgt_q, vec_q;
  logic [ADDR_W-1:0]   pc_q;
  logic [DATA_W-1:0]   spo_q, sto_q;
  logic                done_q;

  isr_nmi_edge i_nmi_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_i   (nmi_i),
    .clear_i (take_nmi),
    .req_o   (nmi_req)
  );

  isr_arbiter i_arbiter (
    .idle_i     (state_q == S_IDLE),
    .nmi_req_i  (nmi_req),
    .irq_i      (irq_i),
    .i_flag_i   (status_i[FLAG_I]),
    .start_i    (start_i),
    .cmd_i      (cmd_i),
    .go_o       (go),
    .take_nmi_o (take_nmi),
    .kind_o     (kind_a)
  );

  assign sp_inc = sp_q + ONE_D;
  assign sp_dec = sp_q - ONE_D;

  // bus command decode
  always_comb begin
    mem_addr_o  = '0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_PUSH_H, S_PUSH_L, S_PUSH_P: begin
        mem_addr_o = {STACK_PAGE, sp_q};
        mem_we_o   = (kind_q != K_RST);
        if (state_q == S_PUSH_H)      mem_wdata_o = val_q[ADDR_W-1:DATA_W];
        else if (state_q == S_PUSH_L) mem_wdata_o = val_q[DATA_W-1:0];
        else                          mem_wdata_o = st_q;
      end
      S_VEC_L: begin
        mem_addr_o = vec_q;
        mem_re_o   = 1'b1;
      end
      S_VEC_H: begin
        mem_addr_o = vec_q + ONE_A;
        mem_re_o   = 1'b1;
      end
      S_POP_P, S_POP_L, S_POP_H: begin
        mem_addr_o = {STACK_PAGE, sp_inc};
        mem_re_o   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      sp_q    <= '0;
      st_q    <= '0;
      val_q   <= '0;
      tgt_q   <= '0;
      vec_q   <= '0;
      pc_q    <= '0;
      spo_q   <= INIT_SP;
      sto_q   <= INIT_ST;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (go) begin
          kind_q <= kind_a;
          sp_q   <= sp_i;
          st_q   <= (kind_a == K_BRK) ? (status_i | B_MASK) : status_i;
          val_q  <= (kind_a == K_CALL) ? (pc_i - ONE_A) : pc_i;
          tgt_q  <= tgt_i;
          vec_q  <= (kind_a == K_NMI) ? NMI_VEC :
                    (kind_a == K_RST) ? RST_VEC : IRQ_VEC;
          unique case (kind_a)
            K_CALL:  state_q <= S_PUSH_H;
            K_RET:   state_q <= S_POP_L;
            K_RETI:  state_q <= S_POP_P;
            default: state_q <= S_PAD;
          endcase
        end
        S_PAD: state_q <= S_PUSH_H;
        S_PUSH_H: begin
          sp_q    <= sp_dec;
          state_q <= S_PUSH_L;
        end
        S_PUSH_L: begin
          sp_q <= sp_dec;
          if (kind_q == K_CALL) begin
            pc_q    <= tgt_q;
            spo_q   <= sp_dec;
            sto_q   <= st_q;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_PUSH_P;
          end
        end
        S_PUSH_P: begin
          sp_q    <= sp_dec;
          st_q    <= st_q | I_MASK;  // set after the status byte leaves
          state_q <= S_VEC_L;
        end
        S_VEC_L: begin
          val_q[DATA_W-1:0] <= mem_rdata_i;
          state_q <= S_VEC_H;
        end
        S_VEC_H: begin
          pc_q    <= {mem_rdata_i, val_q[DATA_W-1:0]};
          spo_q   <= sp_q;
          sto_q   <= st_q;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        S_POP_P: begin
          sp_q    <= sp_inc;
          st_q    <= mem_rdata_i;
          state_q <= S_POP_L;
        end
        S_POP_L: begin
          sp_q <= sp_inc;
          val_q[DATA_W-1:0] <= mem_rdata_i;
          state_q <= S_POP_H;
        end
        S_POP_H: begin
          pc_q    <= {mem_rdata_i, val_q[DATA_W-1:0]} + ADDR_W'(kind_q == K_RET);
          spo_q   <= sp_inc;
          sto_q   <= st_q;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign pc_o     = pc_q;
  assign sp_o     = spo_q;
  assign status_o = sto_q;
  assign kind_o   = kind_q;
endmodule

// File: rtl/isr_stack_seq_chk.sv
module isr_stack_seq_chk #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter int unsigned FLAG_I = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                irq_i,
  input logic                nmi_req_i,
  input logic [DATA_W-1:0]   status_i,
  input logic [2*DATA_W-1:0] mem_addr_o,
  input logic                mem_we_o,
  input logic                mem_re_o,
  input logic [2:0]          kind_o,
  input logic                busy_o,
  input logic                done_o
);
  a_r12_write_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[2*DATA_W-1:DATA_W] == STACK_PAGE);

  a_r12_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r12_bus_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> busy_o);

  a_r3_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_reset_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && kind_o == 3'd4) |-> !mem_we_o);

  a_r6_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && irq_i && status_i[FLAG_I] && !nmi_req_i && !start_i) |=> !busy_o);

  a_r5_nmi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && nmi_req_i) |=> (busy_o && kind_o == 3'd5));
endmodule

bind isr_stack_seq isr_stack_seq_chk #(
  .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE), .FLAG_I(isr_pkg::FLAG_I)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .irq_i(irq_i),
  .nmi_req_i(nmi_req), .status_i(status_i), .mem_addr_o(mem_addr_o),
  .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .kind_o(kind_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_isr_stack_seq.sv
`timescale 1ns/1ps
module test_isr_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi, irq, start;
  logic [2:0]  cmd;
  logic [15:0] pc_in, tgt;
  logic [7:0]  sp_in, st_in;
  logic [7:0]  rdata, wdata;
  logic [15:0] addr, pc_out;
  logic        we, re, busy, done;
  logic [7:0]  sp_out, st_out;
  logic [2:0]  kind;

  logic [7:0] stk [256];
  int wr_cnt = 0, off_wr = 0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  isr_stack_seq i_isr_stack_seq (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .irq_i(irq), .start_i(start),
    .cmd_i(cmd), .pc_i(pc_in), .sp_i(sp_in), .status_i(st_in), .tgt_i(tgt),
    .mem_rdata_i(rdata), .mem_addr_o(addr), .mem_we_o(we), .mem_re_o(re),
    .mem_wdata_o(wdata), .pc_o(pc_out), .sp_o(sp_out), .status_o(st_out),
    .kind_o(kind), .busy_o(busy), .done_o(done)
  );

  function automatic logic [7:0] romb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign rdata = (addr[15:8] == 8'h01) ? stk[addr[7:0]] : romb(addr);

  always @(posedge clk) begin
    if (we) begin
      wr_cnt <= wr_cnt + 1;
      if (addr[15:8] == 8'h01) stk[addr[7:0]] <= wdata;
      else off_wr <= off_wr + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin start = 1'b0; irq = 1'b0; end
    end while (!done && n < 40);
  endtask

  task automatic run_cmd(input logic [2:0] c, input logic [15:0] p, input logic [7:0] s,
                         input logic [7:0] st, input logic [15:0] t, output int n);
    @(negedge clk);
    cmd = c; pc_in = p; sp_in = s; st_in = st; tgt = t; start = 1'b1;
    wait_done(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, w0, bcnt;
    logic [7:0]  s8, st;
    logic [15:0] p, pm1;
    rst_n = 1'b0; nmi = 0; irq = 0; start = 0; cmd = 0;
    pc_in = 0; tgt = 0; sp_in = 0; st_in = 0;
    for (int i = 0; i < 256; i++) stk[i] <= 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 sp", 32'(sp_out), 32'h00FD);
    chk("R1 status", 32'(st_out), 32'h0034);
    chk("R1 pc", 32'(pc_out), 32'h0);
    chk("R1 busy/done/we", 32'({busy, done, we}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 256; s++) begin
      s8  = 8'(s);
      p   = 16'(16'h1000 + 16'(s) * 16'h0101);
      st  = s8 & 8'hEB;
      // R2 R3 R4 R11 break entry
      run_cmd(3'd3, p, s8, st, 16'h0, n);
      chk("R3 brk cycles", 32'(n), 32'd7);
      chk("R2 R11 push pc hi", 32'(stk[s8]), 32'(p[15:8]));
      chk("R2 R11 push pc lo", 32'(stk[8'(s8 - 8'd1)]), 32'(p[7:0]));
      chk("R4 R11 push status", 32'(stk[8'(s8 - 8'd2)]), 32'(st | 8'h10));
      chk("R2 sp", 32'(sp_out), 32'(8'(s8 - 8'd3)));
      chk("R2 vector", 32'(pc_out), 32'({romb(16'hFFFF), romb(16'hFFFE)}));
      chk("R4 status", 32'(st_out), 32'(st | 8'h14));
      // R9 return from interrupt
      run_cmd(3'd2, 16'h0, 8'(s8 - 8'd3), 8'h00, 16'h0, n);
      chk("R9 cycles", 32'(n), 32'd4);
      chk("R9 pc", 32'(pc_out), 32'(p));
      chk("R9 status", 32'(st_out), 32'(st | 8'h10));
      chk("R9 sp", 32'(sp_out), 32'(s8));
      // R7 call
      pm1 = p - 16'd1;
      run_cmd(3'd0, p, s8, st, 16'hBEEF ^ 16'(s), n);
      chk("R7 cycles", 32'(n), 32'd3);
      chk("R7 R11 push hi", 32'(stk[s8]), 32'(pm1[15:8]));
      chk("R7 R11 push lo", 32'(stk[8'(s8 - 8'd1)]), 32'(pm1[7:0]));
      chk("R7 sp", 32'(sp_out), 32'(8'(s8 - 8'd2)));
      chk("R7 pc", 32'(pc_out), 32'(16'hBEEF ^ 16'(s)));
      // R8 return
      run_cmd(3'd1, 16'h0, 8'(s8 - 8'd2), st, 16'h0, n);
      chk("R8 cycles", 32'(n), 32'd3);
      chk("R8 pc", 32'(pc_out), 32'(p));
      chk("R8 sp", 32'(sp_out), 32'(s8));
    end

    // R10 reset entry
    w0 = wr_cnt;
    run_cmd(3'd4, 16'h4444, 8'h80, 8'h30, 16'h0, n);
    chk("R10 cycles", 32'(n), 32'd7);
    chk("R10 no writes", 32'(wr_cnt), 32'(w0));
    chk("R10 sp", 32'(sp_out), 32'h7D);
    chk("R10 pc", 32'(pc_out), 32'({romb(16'hFFFD), romb(16'hFFFC)}));
    chk("R10 status", 32'(st_out), 32'h34);

    // R10 invalid command ignored
    @(negedge clk);
    cmd = 3'd6; start = 1'b1; bcnt = 0;
    repeat (5) begin @(negedge clk); if (busy) bcnt++; end
    start = 1'b0;
    chk("R10 cmd 6 ignored", 32'(bcnt), 32'd0);

    // R6 masked IRQ
    w0 = wr_cnt;
    @(negedge clk);
    st_in = 8'h24; sp_in = 8'h40; irq = 1'b1; bcnt = 0;
    repeat (10) begin @(negedge clk); if (busy) bcnt++; end
    irq = 1'b0;
    chk("R6 masked busy", 32'(bcnt), 32'd0);
    chk("R6 masked writes", 32'(wr_cnt), 32'(w0));

    // R6 IRQ taken
    @(negedge clk);
    sp_in = 8'h50; pc_in = 16'h2345; st_in = 8'h81; irq = 1'b1;
    wait_done(n);
    chk("R3 irq cycles", 32'(n), 32'd7);
    chk("R6 kind", 32'(kind), 32'd6);
    chk("R2 irq hi", 32'(stk[8'h50]), 32'h23);
    chk("R2 irq lo", 32'(stk[8'h4F]), 32'h45);
    chk("R4 irq pushed", 32'(stk[8'h4E]), 32'h81);
    chk("R2 irq vector", 32'(pc_out), 32'({romb(16'hFFFF), romb(16'hFFFE)}));
    chk("R4 irq status", 32'(st_out), 32'h85);

    // R5 NMI beats IRQ
    @(negedge clk);
    sp_in = 8'h60; pc_in = 16'h3456; st_in = 8'h00; nmi = 1'b1; irq = 1'b1;
    wait_done(n);
    chk("R5 kind", 32'(kind), 32'd5);
    chk("R3 nmi cycles", 32'(n), 32'd7);
    chk("R5 nmi vector", 32'(pc_out), 32'({romb(16'hFFFB), romb(16'hFFFA)}));
    chk("R5 nmi status", 32'(st_out), 32'h04);
    chk("R5 nmi sp", 32'(sp_out), 32'h5D);
    bcnt = 0;
    repeat (20) begin @(negedge clk); if (busy) bcnt++; end
    chk("R5 held nmi no repeat", 32'(bcnt), 32'd0);
    nmi = 1'b0;
    @(negedge clk);

    // R5 NMI edge during a call is kept
    @(negedge clk);
    cmd = 3'd0; pc_in = 16'h1111; sp_in = 8'h90; st_in = 8'h00; tgt = 16'h2222; start = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) start = 1'b0;
      if (n == 2) nmi = 1'b1;
    end while (!done && n < 40);
    chk("R7 call kind", 32'(kind), 32'd0);
    chk("R7 call pc", 32'(pc_out), 32'h2222);
    wait_done(n);
    chk("R5 queued nmi kind", 32'(kind), 32'd5);
    chk("R5 queued nmi sp", 32'(sp_out), 32'h8D);
    nmi = 1'b0;

    chk("R12 off-page writes", 32'(off_wr), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule